// File: doc/BRIEF.md
# Command Queue Entry Screener

This block sits at the consume side of a translation unit's command queue. It takes one 128-bit entry per handshake, made of four 32-bit words, and checks the opcode in the low byte of the first word against a sparse list of supported command encodings. When a command is supported, the block raises a one-cycle decode strobe. Along with the strobe it presents the opcode and the operand fields taken from the entry. Executing the command is left to downstream logic.

A failed entry has an unsupported opcode or was flagged as a fetch abort. In that case the block writes an error code into the error field of its consumer view and raises the command-error flag, which is bit 0 of a global error vector. It then drops ready and keeps it low until software acknowledges the error with a clear pulse. The consumer index never moves past a failed entry, so the failing slot can be inspected and replayed. The synchronisation command can also ask for a completion notice, either an interrupt pulse (gated by an enable input) or an event pulse.

Top module: `cmdq_cmd_screen`

## Requirements
- R1: An accepted entry with a supported opcode and no abort flag raises `dec_valid` for exactly one cycle after the accepting edge, shows its opcode on `dec_opcode` and advances `cons_index` by one. The supported opcodes are 0x01-0x07, 0x10-0x13, 0x18, 0x1A, 0x20-0x23, 0x28, 0x2A, 0x30, 0x40, 0x41 and 0x44-0x46.
- R2: Every other opcode is rejected, including 0x00, the gaps such as 0x14 or 0x42, and anything above 0x46. A rejected entry gives `cons_err` = 1, sets `gerr_cmd` (bit 0 of the global error vector) and produces no `dec_valid`. `cons_index` does not change.
- R3: An accepted entry with `in_fetch_abort` high gives `cons_err` = 2 and `gerr_cmd` = 1 whatever its opcode, with no decode and no index change. Code 0 means no error and code 3 is reserved for a sync completion timeout.
- R4: While an error is pending, `in_ready` stays low and the held entry is not consumed. A cycle with `err_clear` high returns `cons_err` to 0, `gerr_cmd` to 0 and `in_ready` to 1 on the next cycle.
- R5: On a decode, `dec_sid` holds word 1, `dec_vmid` holds word 1 bits 15:0 and `dec_asid` holds word 1 bits 31:16. `dec_addr` is {word 3, word 2 bits 31:12, 12'h000}. `dec_attr` holds word 0 bits 31:8 and `dec_low` holds word 2 bits 11:0.
- R6: A decoded sync (0x46) whose word 0 bits 13:12 equal 2 pulses `sync_event` for one cycle, together with `dec_valid`. A value of 1 pulses `sync_irq` only if `irq_en` was high at acceptance. A value of 0, or any other opcode, pulses neither.
- R7: After reset, `in_ready` = 1, `dec_valid` = 0, `cons_err` = 0, `gerr_cmd` = 0 and `cons_index` = 0.
- R8: `cons_index` is LOG2_DEPTH+1 bits wide (5 by default) and wraps from its maximum value to 0.
- R9: Cycles without a handshake (`in_valid` low) produce no decode, no pulse and no index change, whatever the entry bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Entry offered |
| in_ready | output | 1 | Entry can be taken |
| in_entry | input | 128 | Entry, word 0 in bits 31:0 up to word 3 in bits 127:96 |
| in_fetch_abort | input | 1 | Entry fetch ended in an abort |
| irq_en | input | 1 | Interrupt enable for sync completion |
| err_clear | input | 1 | Acknowledge pending error |
| dec_valid | output | 1 | Decode strobe |
| dec_opcode | output | 8 | Decoded opcode |
| dec_attr | output | 24 | Word 0 bits 31:8 |
| dec_sid | output | 32 | Stream identifier (word 1) |
| dec_vmid | output | 16 | Virtual machine identifier |
| dec_asid | output | 16 | Address space identifier |
| dec_addr | output | 64 | Page-aligned address |
| dec_low | output | 12 | Word 2 bits 11:0 |
| sync_irq | output | 1 | Sync completion interrupt pulse |
| sync_event | output | 1 | Sync completion event pulse |
| cons_index | output | 5 | Consumer index with wrap bit |
| cons_err | output | 7 | Error field of the consumer view |
| gerr_cmd | output | 1 | Global command-error flag |

## Verification
The hardest situation to reach from the ports is a stalled queue. The producer keeps offering a legal entry while an error is pending, and that entry must neither be decoded nor move the index until the clear arrives. It must then be taken exactly once. The stimulus sets up this stall by following a rejected opcode with a held, valid, legal entry across several cycles before the clear pulse. The bench also drives all 256 opcode values back to back, which proves the sparse boundaries on both sides of each gap. Further directed entries carry the index across its wrap point.

// File: rtl/cmdq_screen_pkg.sv
`timescale 1ns/1ps
package cmdq_screen_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_WORDS = 4;
  localparam int unsigned ENTRY_W = WORD_W * N_WORDS;
  localparam int unsigned OP_W    = 8;
  localparam int unsigned ERR_W   = 7;

  typedef enum logic [1:0] {
    CERR_NONE         = 2'd0,
    CERR_ILLEGAL      = 2'd1,
    CERR_FETCH_ABORT  = 2'd2,
    CERR_SYNC_TIMEOUT = 2'd3
  } cerr_e;

  typedef enum logic [1:0] {
    DONE_SILENT = 2'd0,
    DONE_IRQ    = 2'd1,
    DONE_EVENT  = 2'd2,
    DONE_RSVD   = 2'd3
  } done_sel_e;

  localparam logic [OP_W-1:0] OP_SYNC = 8'h46;

  typedef struct packed {
    logic [OP_W-1:0]  opcode;
    logic [23:0]      attr;
    done_sel_e        done_sel;
    logic [31:0]      sid;
    logic [15:0]      vmid;
    logic [15:0]      asid;
    logic [63:0]      addr;
    logic [11:0]      low;
  } cmd_fields_t;
endpackage

// File: rtl/cmdq_op_classify.sv
`timescale 1ns/1ps
module cmdq_op_classify
  import cmdq_screen_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output logic            supported
);
  // Sparse table of accepted encodings; everything else is illegal.
  always_comb begin
    case (opcode) inside
      [8'h01:8'h07],
      [8'h10:8'h13], 8'h18, 8'h1A,
      [8'h20:8'h23], 8'h28, 8'h2A, 8'h30,
      8'h40, 8'h41, [8'h44:8'h46]: supported = 1'b1;
      default:                     supported = 1'b0;
    endcase
  end
endmodule

// File: rtl/cmdq_field_extract.sv
`timescale 1ns/1ps
module cmdq_field_extract
  import cmdq_screen_pkg::*;
(
  input  logic [ENTRY_W-1:0] entry,
  output cmd_fields_t        fields
);
  logic [WORD_W-1:0] word [N_WORDS];

  for (genvar g = 0; g < N_WORDS; g++) begin : g_split
    assign word[g] = entry[g*WORD_W +: WORD_W];
  end

  always_comb begin
    fields.opcode   = word[0][OP_W-1:0];
    fields.attr     = word[0][31:8];
    fields.done_sel = done_sel_e'(word[0][13:12]);
    fields.sid      = word[1];
    fields.vmid     = word[1][15:0];
    fields.asid     = word[1][31:16];
    fields.addr     = {word[3], word[2][31:12], 12'h000};
    fields.low      = word[2][11:0];
  end
endmodule

// File: rtl/cmdq_err_ctrl.sv
`timescale 1ns/1ps
module cmdq_err_ctrl
  import cmdq_screen_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             supported,
  input  logic             abort,
  input  logic             clear,
  output logic             halted,
  output cerr_e            code,
  output logic [IDX_W-1:0] index
);
  always_ff @(posedge clk) begin
    if (rst) begin
      halted <= 1'b0;
      code   <= CERR_NONE;
      index  <= '0;
    end else if (halted) begin
      if (clear) begin
        halted <= 1'b0;
        code   <= CERR_NONE;
      end
    end else if (take) begin
      if (abort) begin
        halted <= 1'b1;
        code   <= CERR_FETCH_ABORT;
      end else if (!supported) begin
        halted <= 1'b1;
        code   <= CERR_ILLEGAL;
      end else begin
        index  <= index + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmdq_cmd_screen.sv
`timescale 1ns/1ps
module cmdq_cmd_screen
  import cmdq_screen_pkg::*;
#(
  parameter int unsigned LOG2_DEPTH = 4,
  localparam int unsigned IDX_W = LOG2_DEPTH + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [ENTRY_W-1:0] in_entry,
  input  logic               in_fetch_abort,
  input  logic               irq_en,
  input  logic               err_clear,
  output logic               dec_valid,
  output logic [OP_W-1:0]    dec_opcode,
  output logic [23:0]        dec_attr,
  output logic [31:0]        dec_sid,
  output logic [15:0]        dec_vmid,
  output logic [15:0]        dec_asid,
  output logic [63:0]        dec_addr,
  output logic [11:0]        dec_low,
  output logic               sync_irq,
  output logic               sync_event,
  output logic [IDX_W-1:0]   cons_index,
  output logic [ERR_W-1:0]   cons_err,
  output logic               gerr_cmd
);
  cmd_fields_t fields;
  logic        supported;
  logic        halted;
  cerr_e       code;
  logic        take;
  logic        good;

  cmdq_field_extract u_extract (
    .entry  (in_entry),
    .fields (fields)
  );

  cmdq_op_classify u_classify (
    .opcode    (fields.opcode),
    .supported (supported)
  );

  cmdq_err_ctrl #(.IDX_W(IDX_W)) u_err (
    .clk       (clk),
    .rst       (rst),
    .take      (take),
    .supported (supported),
    .abort     (in_fetch_abort),
    .clear     (err_clear),
    .halted    (halted),
    .code      (code),
    .index     (cons_index)
  );

  assign in_ready = !halted;
  assign take     = in_valid && in_ready;
  assign good     = take && supported && !in_fetch_abort;
  assign gerr_cmd = halted;
  assign cons_err = {{(ERR_W-2){1'b0}}, code};

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      sync_irq   <= 1'b0;
      sync_event <= 1'b0;
      dec_opcode <= '0;
      dec_attr   <= '0;
      dec_sid    <= '0;
      dec_vmid   <= '0;
      dec_asid   <= '0;
      dec_addr   <= '0;
      dec_low    <= '0;
    end else begin
      dec_valid  <= good;
      sync_irq   <= good && (fields.opcode == OP_SYNC) &&
                    (fields.done_sel == DONE_IRQ) && irq_en;
      sync_event <= good && (fields.opcode == OP_SYNC) &&
                    (fields.done_sel == DONE_EVENT);
      if (good) begin
        dec_opcode <= fields.opcode;
        dec_attr   <= fields.attr;
        dec_sid    <= fields.sid;
        dec_vmid   <= fields.vmid;
        dec_asid   <= fields.asid;
        dec_addr   <= fields.addr;
        dec_low    <= fields.low;
      end
    end
  end
endmodule

// File: rtl/cmdq_cmd_screen_sva.sv
`timescale 1ns/1ps
module cmdq_cmd_screen_sva #(
  parameter int unsigned IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic             err_clear,
  input logic             dec_valid,
  input logic [7:0]       dec_opcode,
  input logic             sync_irq,
  input logic             sync_event,
  input logic [IDX_W-1:0] cons_index,
  input logic [6:0]       cons_err,
  input logic             gerr_cmd
);
  AST_TAKE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (dec_valid != gerr_cmd));                   // R1
  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> (cons_index == IDX_W'($past(cons_index) + 1'b1)));       // R1
  AST_ERR_HOLDS_INDEX: assert property (@(posedge clk) disable iff (rst)
    $rose(gerr_cmd) |-> $stable(cons_index));                             // R2
  AST_ERR_CODED: assert property (@(posedge clk) disable iff (rst)
    gerr_cmd |-> (cons_err != 7'd0));                                     // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !err_clear) |=> (!in_ready && $stable(cons_index) && !dec_valid)); // R4
  AST_CLEAR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (gerr_cmd && err_clear) |=> (in_ready && cons_err == 7'd0 && !gerr_cmd)); // R4
  AST_SYNC_ONLY_DECODED: assert property (@(posedge clk) disable iff (rst)
    (sync_irq || sync_event) |-> (dec_valid && dec_opcode == 8'h46));      // R6
  AST_SYNC_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(sync_irq && sync_event));                                           // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!dec_valid && $stable(cons_index)));                   // R9
endmodule

bind cmdq_cmd_screen cmdq_cmd_screen_sva #(.IDX_W(IDX_W)) u_sva (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .err_clear  (err_clear),
  .dec_valid  (dec_valid),
  .dec_opcode (dec_opcode),
  .sync_irq   (sync_irq),
  .sync_event (sync_event),
  .cons_index (cons_index),
  .cons_err   (cons_err),
  .gerr_cmd   (gerr_cmd)
);

// File: tb/cmdq_cmd_screen_bench.sv
`timescale 1ns/1ps
module cmdq_cmd_screen_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_entry = '0;
  logic         in_fetch_abort = 1'b0;
  logic         irq_en = 1'b0;
  logic         err_clear = 1'b0;
  logic         dec_valid;
  logic [7:0]   dec_opcode;
  logic [23:0]  dec_attr;
  logic [31:0]  dec_sid;
  logic [15:0]  dec_vmid;
  logic [15:0]  dec_asid;
  logic [63:0]  dec_addr;
  logic [11:0]  dec_low;
  logic         sync_irq;
  logic         sync_event;
  logic [4:0]   cons_index;
  logic [6:0]   cons_err;
  logic         gerr_cmd;

  int total = 0;
  int bad   = 0;
  logic [4:0] exp_idx = '0;

  always #2.5 clk = ~clk;

  cmdq_cmd_screen u_cmdq_cmd_screen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_entry(in_entry), .in_fetch_abort(in_fetch_abort), .irq_en(irq_en),
    .err_clear(err_clear), .dec_valid(dec_valid), .dec_opcode(dec_opcode),
    .dec_attr(dec_attr), .dec_sid(dec_sid), .dec_vmid(dec_vmid),
    .dec_asid(dec_asid), .dec_addr(dec_addr), .dec_low(dec_low),
    .sync_irq(sync_irq), .sync_event(sync_event), .cons_index(cons_index),
    .cons_err(cons_err), .gerr_cmd(gerr_cmd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit op_allowed(input int op);
    int ok_list[25] = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07,
                        8'h10, 8'h11, 8'h12, 8'h13, 8'h18, 8'h1A,
                        8'h20, 8'h21, 8'h22, 8'h23, 8'h28, 8'h2A, 8'h30,
                        8'h40, 8'h41, 8'h44, 8'h45, 8'h46};
    foreach (ok_list[i]) if (ok_list[i] == op) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [127:0] mk(input logic [7:0] op, input logic [1:0] sel,
                                      input logic [31:0] w1, input logic [31:0] w2,
                                      input logic [31:0] w3);
    return {w3, w2, w1, 18'h0, sel, 4'h0, op};
  endfunction

  // Offer one entry for one cycle; outputs are sampled at the following negedge.
  task automatic offer(input logic [127:0] e, input logic ab);
    @(negedge clk);
    in_entry = e; in_fetch_abort = ab; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_fetch_abort = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
  endtask

  task automatic t_reset();
    chk("R7 ready", in_ready, 1);
    chk("R7 dec_valid", dec_valid, 0);
    chk("R7 cons_err", cons_err, 0);
    chk("R7 gerr", gerr_cmd, 0);
    chk("R7 index", cons_index, 0);
  endtask

  task automatic t_sweep();
    for (int op = 0; op < 256; op++) begin
      offer(mk(op[7:0], 2'd0, 32'h0, 32'h0, 32'h0), 1'b0);
      if (op_allowed(op)) begin
        exp_idx = exp_idx + 1'b1;
        chk("R1 dec_valid", dec_valid, 1);
        chk("R1 opcode", dec_opcode, op);
        chk("R1 index", cons_index, exp_idx);
      end else begin
        chk("R2 dec_valid", dec_valid, 0);
        chk("R2 cons_err", cons_err, 1);
        chk("R2 gerr", gerr_cmd, 1);
        chk("R2 index", cons_index, exp_idx);
        pulse_clear();
        chk("R4 ready after clear", in_ready, 1);
      end
    end
  endtask

  task automatic t_fields();
    offer(mk(8'h12, 2'd3, 32'hA5A5_1234, 32'hDEAD_BF0C, 32'h0000_00C3), 1'b0);
    exp_idx = exp_idx + 1'b1;
    chk("R5 sid", dec_sid, 32'hA5A5_1234);
    chk("R5 vmid", dec_vmid, 16'h1234);
    chk("R5 asid", dec_asid, 16'hA5A5);
    chk("R5 addr", dec_addr, 64'h0000_00C3_DEAD_B000);
    chk("R5 low", dec_low, 12'hF0C);
    chk("R5 attr", dec_attr, 24'h000030);
  endtask

  task automatic t_sync();
    irq_en = 1'b0;
    offer(mk(8'h46, 2'd2, 0, 0, 0), 1'b0); exp_idx = exp_idx + 1'b1;
    chk("R6 event pulse", sync_event, 1);
    chk("R6 no irq on event", sync_irq, 0);
    @(negedge clk);
    chk("R6 event one cycle", sync_event, 0);
    offer(mk(8'h46, 2'd1, 0, 0, 0), 1'b0); exp_idx = exp_idx + 1'b1;
    chk("R6 irq masked", sync_irq, 0);
    irq_en = 1'b1;
    offer(mk(8'h46, 2'd1, 0, 0, 0), 1'b0); exp_idx = exp_idx + 1'b1;
    chk("R6 irq pulse", sync_irq, 1);
    chk("R6 no event on irq", sync_event, 0);
    offer(mk(8'h46, 2'd0, 0, 0, 0), 1'b0); exp_idx = exp_idx + 1'b1;
    chk("R6 silent irq", sync_irq, 0);
    chk("R6 silent event", sync_event, 0);
    offer(mk(8'h45, 2'd2, 0, 0, 0), 1'b0); exp_idx = exp_idx + 1'b1;
    chk("R6 non-sync event", sync_event, 0);
    irq_en = 1'b0;
  endtask

  task automatic t_abort();
    offer(mk(8'h30, 2'd0, 0, 0, 0), 1'b1);
    chk("R3 cons_err", cons_err, 2);
    chk("R3 gerr", gerr_cmd, 1);
    chk("R3 no decode", dec_valid, 0);
    chk("R3 index", cons_index, exp_idx);
    pulse_clear();
    chk("R3 cleared", cons_err, 0);
  endtask

  task automatic t_stall();
    offer(mk(8'h42, 2'd0, 0, 0, 0), 1'b0);
    chk("R4 ready low", in_ready, 0);
    @(negedge clk);
    in_entry = mk(8'h01, 2'd0, 0, 0, 0); in_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R4 stall no decode", dec_valid, 0);
      chk("R4 stall index", cons_index, exp_idx);
      chk("R4 stall ready", in_ready, 0);
    end
    err_clear = 1'b1;
    @(negedge clk);
    err_clear = 1'b0;
    chk("R4 release ready", in_ready, 1);
    chk("R4 release err", cons_err, 0);
    chk("R4 release gerr", gerr_cmd, 0);
    @(negedge clk);
    in_valid = 1'b0;
    exp_idx = exp_idx + 1'b1;
    chk("R4 held entry taken", dec_valid, 1);
    chk("R4 taken once index", cons_index, exp_idx);
    @(negedge clk);
    chk("R4 taken once", dec_valid, 0);
  endtask

  task automatic t_idle();
    in_entry = mk(8'h46, 2'd2, 32'hFFFF_FFFF, 0, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9 idle decode", dec_valid, 0);
      chk("R9 idle event", sync_event, 0);
      chk("R9 idle index", cons_index, exp_idx);
    end
  endtask

  task automatic t_wrap();
    while (exp_idx != 5'd31) begin
      offer(mk(8'h01, 2'd0, 0, 0, 0), 1'b0);
      exp_idx = exp_idx + 1'b1;
    end
    chk("R8 at top", cons_index, 31);
    offer(mk(8'h07, 2'd0, 0, 0, 0), 1'b0);
    exp_idx = 5'd0;
    chk("R8 wrapped", cons_index, 0);
    offer(mk(8'h10, 2'd0, 0, 0, 0), 1'b0);
    exp_idx = 5'd1;
    chk("R8 after wrap", cons_index, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sweep();
    t_fields();
    t_sync();
    t_abort();
    t_stall();
    t_idle();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule